// File: doc/BRIEF.md
# SDRAM Command Sequencer with Auto-Refresh

This block sits between a simple request port and the command pins of a four-bank synchronous DRAM. A client presents one request at a time: a read, write, refresh or mode-set operation together with a bank, a row, a column and an auto-precharge flag. The sequencer turns each request into the right run of strobe commands, keeps track of which row is open in every bank, and holds back every command until the minimum spacing since earlier commands has passed. Each of those spacings is a down-counter loaded with a cycle count that is derived from nanosecond parameters and the clock period.

A row hit goes straight to the column command. A miss on a closed bank activates the row first, and a miss on a bank that holds another row precharges it, activates the new row and then issues the column command. A free-running interval timer requests auto-refresh often enough to meet 4096 rows per 64 ms. When it fires, the sequencer finishes the request it is working on, closes all banks if any is open, issues the refresh and only then accepts new work. After reset it waits out a power-up delay with no-operations, closes all banks, refreshes twice and loads a default mode word before it raises ready for the first time.

The FSM states are ST_BOOT (power-up wait), ST_BOOT_PALL, ST_BOOT_REF1, ST_BOOT_REF2, ST_BOOT_MODE, ST_IDLE, ST_PRE, ST_ACT, ST_COL, ST_PALL, ST_REF and ST_MODE. The boot chain runs ST_BOOT to ST_BOOT_PALL to ST_BOOT_REF1 to ST_BOOT_REF2 to ST_BOOT_MODE to ST_IDLE. From ST_IDLE a read or write goes to ST_COL on a hit, to ST_ACT when the bank is closed and to ST_PRE when another row is open. ST_PRE leads to ST_ACT, ST_ACT leads to ST_COL, and ST_COL returns to ST_IDLE. A refresh, whether pending or requested, goes to ST_PALL when any bank is open and to ST_REF otherwise. A mode set goes to ST_PALL or to ST_MODE in the same way. ST_PALL continues to ST_MODE for a mode set and to ST_REF otherwise, and ST_REF and ST_MODE both return to ST_IDLE. Each issuing state holds and outputs a no-operation until its counters allow the command.

Top module: `sdram_cmd_seq`

## Requirements
- R1: Commands are driven on {cs_n, ras_n, cas_n, we_n} as: no-operation 0111, activate 0011, read 0101, write 0100, precharge 0010, auto refresh 0001, mode set 0000. No other pattern appears after reset.
- R2: During and after reset the outputs carry only no-operations for INIT_CYC cycles. After that the first four commands are a precharge with address bit 10 high, two auto refreshes, and a mode set carrying INIT_MODE on the address. Ready stays low until all four have been issued.
- R3: Ready is high only when the sequencer is idle with no refresh pending, and in every cycle in which ready is high the command is a no-operation.
- R4: Request op codes are 0 read, 1 write, 2 refresh and 3 mode set. Read and write requests produce their column command in acceptance order with the requested bank on the bank pins, the column on address bits 7:0 and the auto-precharge flag on address bit 10. Activate carries the row on address bits 10:0. A hit issues no activate or precharge. A miss on a closed bank issues exactly one activate, and a miss on a bank holding another row issues one precharge (bit 10 low) and one activate.
- R5: A column command with address bit 10 high leaves the bank closed, so the next access to that bank activates it again.
- R6: In one bank, activate to column is at least T_RCD cycles, precharge to activate is at least T_RP cycles, activate to activate is at least T_RC cycles and activate to precharge is at least T_RAS cycles. Activates to any two banks are at least T_RRD cycles apart.
- R7: A mode-set request closes all open banks first and drives the request row field on the address. No command follows a mode set for T_MRD (2) cycles.
- R8: Auto refresh is issued only when every bank is closed and at least T_RP cycles after the last precharge. No command follows it for T_RC cycles.
- R9: Auto refresh recurs at intervals of at most REF_CYC plus 40 cycles, where REF_CYC is the floor of (64 ms / 4096) divided by the clock period.
- R10: A refresh request produces an auto refresh within 30 cycles of its acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted on a cycle with req_valid high |
| req_op | input | 2 | 0 read, 1 write, 2 refresh, 3 mode set |
| req_bank | input | 2 | Target bank |
| req_row | input | 11 | Row address; mode word for a mode set |
| req_col | input | 8 | Column address |
| req_ap | input | 1 | Close the bank after the column command |
| cmd_cs_n | output | 1 | Chip select strobe, low active |
| cmd_ras_n | output | 1 | Row strobe, low active |
| cmd_cas_n | output | 1 | Column strobe, low active |
| cmd_we_n | output | 1 | Write enable strobe, low active |
| cmd_ba | output | 2 | Bank select |
| cmd_addr | output | 11 | Multiplexed row, column or mode address |

## Verification
The in-line assertions watch on every cycle that an activate never targets an open bank and a precharge never targets a closed one, and that auto refresh only leaves with every bank closed. They also check that ready coincides with a no-operation, that a pending refresh stays pending until one is issued, and that the cycle after an activate or a mode set carries no column command or no command at all. The bench scoreboard covers what needs a history: whether a request was a hit or a miss and so how many activates and precharges it cost, the exact gaps against T_RCD, T_RP, T_RC, T_RAS and T_RRD, the boot order, and the refresh interval over thousands of idle cycles.

// File: rtl/sdseq_pkg.sv
package sdseq_pkg;

    // Strobe pattern {cs_n, ras_n, cas_n, we_n}
    typedef enum logic [3:0] {
        CMD_MODE  = 4'b0000,
        CMD_AREF  = 4'b0001,
        CMD_PRECH = 4'b0010,
        CMD_ACTV  = 4'b0011,
        CMD_WRITE = 4'b0100,
        CMD_READ  = 4'b0101,
        CMD_NOP   = 4'b0111
    } cmd_e;

    typedef enum logic [1:0] {
        OP_RD   = 2'd0,
        OP_WR   = 2'd1,
        OP_REF  = 2'd2,
        OP_MODE = 2'd3
    } op_e;

    typedef enum logic [3:0] {
        ST_BOOT,
        ST_BOOT_PALL,
        ST_BOOT_REF1,
        ST_BOOT_REF2,
        ST_BOOT_MODE,
        ST_IDLE,
        ST_PRE,
        ST_ACT,
        ST_COL,
        ST_PALL,
        ST_REF,
        ST_MODE
    } state_e;

    // Round a time in ns up to whole clock cycles of period ps
    function automatic int ns_to_cyc(input int ns, input int ps);
        return (ns * 1000 + ps - 1) / ps;
    endfunction

endpackage

// File: rtl/sd_gap_timer.sv
module sd_gap_timer #(
    parameter int W       = 4,
    parameter int RST_VAL = 0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] gap,
    output logic         zero
);
    logic [W-1:0] cnt;
    logic [W-1:0] dec;
    logic [W-1:0] want;

    always_comb begin
        dec  = (cnt == '0) ? '0 : cnt - 1'b1;
        want = (gap == '0) ? '0 : gap - 1'b1;
    end

    // A load only ever lengthens the remaining wait
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= W'(RST_VAL);
        else if (load && (want > dec))
            cnt <= want;
        else
            cnt <= dec;
    end

    assign zero = (cnt == '0);

    assert_load_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (load && gap > W'(1)) |=> !zero);

endmodule

// File: rtl/sd_bank_rows.sv
module sd_bank_rows #(
    parameter int BANKS = 4,
    parameter int ROW_W = 11,
    localparam int BA_W = $clog2(BANKS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             act_en,
    input  logic [BA_W-1:0]  act_bank,
    input  logic [ROW_W-1:0] act_row,
    input  logic             close_en,
    input  logic [BA_W-1:0]  close_bank,
    input  logic             close_all,
    input  logic [BA_W-1:0]  q_bank,
    input  logic [ROW_W-1:0] q_row,
    output logic             q_open,
    output logic             q_hit,
    output logic [BANKS-1:0] open_mask
);
    logic [BANKS-1:0] open_q;
    logic [ROW_W-1:0] row_q [BANKS];

    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                open_q[b] <= 1'b0;
                row_q[b]  <= '0;
            end else if (act_en && act_bank == BA_W'(b)) begin
                open_q[b] <= 1'b1;
                row_q[b]  <= act_row;
            end else if (close_all || (close_en && close_bank == BA_W'(b))) begin
                open_q[b] <= 1'b0;
            end
        end
    end

    always_comb begin
        q_open = open_q[q_bank];
        q_hit  = open_q[q_bank] && (row_q[q_bank] == q_row);
    end

    assign open_mask = open_q;

    assert_act_closed_R4: assert property (@(posedge clk) disable iff (!rst_n)
        act_en |-> !open_q[act_bank]);
    assert_close_open_R4: assert property (@(posedge clk) disable iff (!rst_n)
        close_en |-> open_q[close_bank]);

endmodule

// File: rtl/sd_refresh_tick.sv
module sd_refresh_tick #(
    parameter int PERIOD = 1953,
    localparam int PW    = $clog2(PERIOD + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic pending
);
    logic [PW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt     <= PW'(PERIOD - 1);
            pending <= 1'b0;
        end else if (restart) begin
            cnt     <= PW'(PERIOD - 1);
            pending <= 1'b0;
        end else if (cnt == '0) begin
            cnt     <= PW'(PERIOD - 1);
            pending <= 1'b1;
        end else begin
            cnt <= cnt - 1'b1;
        end
    end

    assert_pending_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && !restart) |=> pending);
    assert_restart_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> !pending);

endmodule

// File: rtl/sdram_cmd_seq.sv
module sdram_cmd_seq
    import sdseq_pkg::*;
#(
    parameter int          CLK_PS        = 8000,
    parameter int          T_RCD_NS      = 20,
    parameter int          T_RP_NS       = 20,
    parameter int          T_RC_NS       = 63,
    parameter int          T_RAS_NS      = 42,
    parameter int          T_RRD_NS      = 14,
    parameter int          T_MRD_CYC     = 2,
    parameter int          BURST_CYC     = 4,
    parameter int          REF_WINDOW_NS = 64_000_000,
    parameter int          REF_ROWS      = 4096,
    parameter int          INIT_NS       = 100_000,
    parameter int          BANKS         = 4,
    parameter int          ROW_W         = 11,
    parameter int          COL_W         = 8,
    parameter logic [10:0] INIT_MODE     = 11'h032
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [1:0]       req_op,
    input  logic [1:0]       req_bank,
    input  logic [ROW_W-1:0] req_row,
    input  logic [COL_W-1:0] req_col,
    input  logic             req_ap,
    output logic             cmd_cs_n,
    output logic             cmd_ras_n,
    output logic             cmd_cas_n,
    output logic             cmd_we_n,
    output logic [1:0]       cmd_ba,
    output logic [ROW_W-1:0] cmd_addr
);
    localparam int BA_W     = $clog2(BANKS);
    localparam int AP_BIT   = 10;
    localparam int T_RCD    = ns_to_cyc(T_RCD_NS, CLK_PS);
    localparam int T_RP     = ns_to_cyc(T_RP_NS, CLK_PS);
    localparam int T_RC     = ns_to_cyc(T_RC_NS, CLK_PS);
    localparam int T_RAS    = ns_to_cyc(T_RAS_NS, CLK_PS);
    localparam int T_RRD    = ns_to_cyc(T_RRD_NS, CLK_PS);
    localparam int INIT_CYC = ns_to_cyc(INIT_NS, CLK_PS);
    localparam int REF_CYC  = ((REF_WINDOW_NS / REF_ROWS) * 1000) / CLK_PS;
    localparam int AP_GAP   = T_RAS + BURST_CYC + T_RP;
    localparam int MAX_GAP  = AP_GAP + T_RC + T_MRD_CYC;
    localparam int TW       = $clog2(MAX_GAP + 1);
    localparam int IW       = $clog2(INIT_CYC + 2);

    state_e state, state_nx;
    cmd_e   cmd;
    logic   go;

    // Accepted request
    op_e              r_op;
    logic [BA_W-1:0]  r_bank;
    logic [ROW_W-1:0] r_row;
    logic [COL_W-1:0] r_col;
    logic             r_ap;

    // Timer and bank status
    logic [BANKS-1:0] act_zero, col_zero, pre_zero;
    logic [BANKS-1:0] open_mask;
    logic             rrd_zero, busy_zero, boot_zero;
    logic             q_open, q_hit;
    logic             ref_pending;
    logic             all_act_ok, all_pre_ok, accept;

    // Issue strobes
    logic iss_act, iss_pre, iss_pall, iss_col, iss_ref, iss_mode;

    assign all_act_ok = &act_zero;
    assign all_pre_ok = &(pre_zero | ~open_mask);
    assign req_ready  = (state == ST_IDLE) && !ref_pending;
    assign accept     = req_valid && req_ready;

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_BOOT;
        else
            state <= state_nx;
    end

    // ---------------- request register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_op   <= OP_RD;
            r_bank <= '0;
            r_row  <= '0;
            r_col  <= '0;
            r_ap   <= 1'b0;
        end else if (state == ST_IDLE) begin
            if (ref_pending) begin
                r_op <= OP_REF;
            end else if (accept) begin
                r_op   <= op_e'(req_op);
                r_bank <= req_bank;
                r_row  <= req_row;
                r_col  <= req_col;
                r_ap   <= req_ap;
            end
        end
    end

    // ---------------- command outputs ----------------
    always_comb begin
        cmd      = CMD_NOP;
        cmd_ba   = '0;
        cmd_addr = '0;
        go       = 1'b0;
        unique case (state)
            ST_BOOT: ;
            ST_IDLE: ;
            ST_BOOT_PALL, ST_PALL: begin
                go = busy_zero && all_pre_ok;
                if (go) begin
                    cmd              = CMD_PRECH;
                    cmd_addr[AP_BIT] = 1'b1;
                end
            end
            ST_BOOT_REF1, ST_BOOT_REF2, ST_REF: begin
                go = busy_zero && all_act_ok;
                if (go) cmd = CMD_AREF;
            end
            ST_BOOT_MODE: begin
                go = busy_zero && all_act_ok;
                if (go) begin
                    cmd      = CMD_MODE;
                    cmd_addr = ROW_W'(INIT_MODE);
                end
            end
            ST_MODE: begin
                go = busy_zero && all_act_ok;
                if (go) begin
                    cmd      = CMD_MODE;
                    cmd_addr = r_row;
                end
            end
            ST_PRE: begin
                go = busy_zero && pre_zero[r_bank];
                if (go) begin
                    cmd    = CMD_PRECH;
                    cmd_ba = r_bank;
                end
            end
            ST_ACT: begin
                go = busy_zero && act_zero[r_bank] && rrd_zero;
                if (go) begin
                    cmd      = CMD_ACTV;
                    cmd_ba   = r_bank;
                    cmd_addr = r_row;
                end
            end
            ST_COL: begin
                go = busy_zero && col_zero[r_bank];
                if (go) begin
                    cmd                = (r_op == OP_WR) ? CMD_WRITE : CMD_READ;
                    cmd_ba             = r_bank;
                    cmd_addr[COL_W-1:0] = r_col;
                    cmd_addr[AP_BIT]   = r_ap;
                end
            end
        endcase
    end

    assign {cmd_cs_n, cmd_ras_n, cmd_cas_n, cmd_we_n} = cmd;

    // ---------------- next state ----------------
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_BOOT:      if (boot_zero) state_nx = ST_BOOT_PALL;
            ST_BOOT_PALL: if (go) state_nx = ST_BOOT_REF1;
            ST_BOOT_REF1: if (go) state_nx = ST_BOOT_REF2;
            ST_BOOT_REF2: if (go) state_nx = ST_BOOT_MODE;
            ST_BOOT_MODE: if (go) state_nx = ST_IDLE;
            ST_IDLE: begin
                if (ref_pending) begin
                    state_nx = (|open_mask) ? ST_PALL : ST_REF;
                end else if (accept) begin
                    unique case (op_e'(req_op))
                        OP_RD, OP_WR: state_nx = q_hit ? ST_COL : (q_open ? ST_PRE : ST_ACT);
                        OP_REF:       state_nx = (|open_mask) ? ST_PALL : ST_REF;
                        OP_MODE:      state_nx = (|open_mask) ? ST_PALL : ST_MODE;
                    endcase
                end
            end
            ST_PRE:  if (go) state_nx = ST_ACT;
            ST_ACT:  if (go) state_nx = ST_COL;
            ST_COL:  if (go) state_nx = ST_IDLE;
            ST_PALL: if (go) state_nx = (r_op == OP_MODE) ? ST_MODE : ST_REF;
            ST_REF:  if (go) state_nx = ST_IDLE;
            ST_MODE: if (go) state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        iss_act  = go && (state == ST_ACT);
        iss_pre  = go && (state == ST_PRE);
        iss_pall = go && (state == ST_PALL || state == ST_BOOT_PALL);
        iss_col  = go && (state == ST_COL);
        iss_ref  = go && (state == ST_REF || state == ST_BOOT_REF1 || state == ST_BOOT_REF2);
        iss_mode = go && (state == ST_MODE || state == ST_BOOT_MODE);
    end

    // ---------------- per-bank spacing counters ----------------
    for (genvar b = 0; b < BANKS; b++) begin : g_tim
        logic          sel;
        logic          act_ld, col_ld, pre_ld;
        logic [TW-1:0] act_gap, col_gap, pre_gap;

        always_comb begin
            sel     = (r_bank == BA_W'(b));
            act_ld  = 1'b0;
            act_gap = TW'(1);
            col_ld  = iss_act && sel;
            col_gap = TW'(T_RCD);
            pre_ld  = 1'b0;
            pre_gap = TW'(1);
            if (iss_act && sel) begin
                act_ld  = 1'b1;
                act_gap = TW'(T_RC);
                pre_ld  = 1'b1;
                pre_gap = TW'(T_RAS);
            end else if ((iss_pre && sel) || iss_pall) begin
                act_ld  = 1'b1;
                act_gap = TW'(T_RP);
            end else if (iss_col && sel) begin
                pre_ld  = 1'b1;
                pre_gap = TW'(BURST_CYC);
                act_ld  = r_ap;
                act_gap = TW'(AP_GAP);
            end else if (iss_ref) begin
                act_ld  = 1'b1;
                act_gap = TW'(T_RC);
            end
        end

        sd_gap_timer #(.W(TW), .RST_VAL(0)) u_act (
            .clk(clk), .rst_n(rst_n), .load(act_ld), .gap(act_gap), .zero(act_zero[b]));
        sd_gap_timer #(.W(TW), .RST_VAL(0)) u_col (
            .clk(clk), .rst_n(rst_n), .load(col_ld), .gap(col_gap), .zero(col_zero[b]));
        sd_gap_timer #(.W(TW), .RST_VAL(0)) u_pre (
            .clk(clk), .rst_n(rst_n), .load(pre_ld), .gap(pre_gap), .zero(pre_zero[b]));
    end

    // ---------------- global counters ----------------
    logic          busy_ld;
    logic [TW-1:0] busy_gap;

    always_comb begin
        busy_ld  = iss_ref || iss_mode;
        busy_gap = iss_ref ? TW'(T_RC) : TW'(T_MRD_CYC);
    end

    sd_gap_timer #(.W(TW), .RST_VAL(0)) u_rrd (
        .clk(clk), .rst_n(rst_n), .load(iss_act), .gap(TW'(T_RRD)), .zero(rrd_zero));
    sd_gap_timer #(.W(TW), .RST_VAL(0)) u_busy (
        .clk(clk), .rst_n(rst_n), .load(busy_ld), .gap(busy_gap), .zero(busy_zero));
    sd_gap_timer #(.W(IW), .RST_VAL(INIT_CYC)) u_boot (
        .clk(clk), .rst_n(rst_n), .load(1'b0), .gap(IW'(1)), .zero(boot_zero));

    sd_bank_rows #(.BANKS(BANKS), .ROW_W(ROW_W)) u_rows (
        .clk        (clk),
        .rst_n      (rst_n),
        .act_en     (iss_act),
        .act_bank   (r_bank),
        .act_row    (r_row),
        .close_en   (iss_pre || (iss_col && r_ap)),
        .close_bank (r_bank),
        .close_all  (iss_pall),
        .q_bank     (req_bank),
        .q_row      (req_row),
        .q_open     (q_open),
        .q_hit      (q_hit),
        .open_mask  (open_mask)
    );

    sd_refresh_tick #(.PERIOD(REF_CYC)) u_tick (
        .clk(clk), .rst_n(rst_n), .restart(iss_ref), .pending(ref_pending));

    // ---------------- assertions ----------------
    assert_ready_nop_R3: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (cmd == CMD_NOP));
    assert_ref_closed_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_AREF) |-> (open_mask == '0));

    if (T_RCD >= 2) begin : g_rcd_chk
        assert_act_col_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (cmd == CMD_ACTV) |=> !(cmd == CMD_READ || cmd == CMD_WRITE));
    end
    if (T_MRD_CYC >= 2) begin : g_mrd_chk
        assert_mode_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (cmd == CMD_MODE) |=> (cmd == CMD_NOP));
    end

endmodule

// File: tb/sdram_cmd_seq_test.sv
`timescale 1ns/1ps
module sdram_cmd_seq_test;

    localparam int T_RCD = 3, T_RP = 3, T_RC = 8, T_RAS = 6, T_RRD = 2, T_MRD = 2;
    localparam int INIT_CYC = 12500;
    localparam int REF_CYC  = 1953;
    localparam logic [10:0] BOOT_MODE = 11'h032;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic req_ready;
    logic [1:0] req_op = 2'd0;
    logic [1:0] req_bank = 2'd0;
    logic [10:0] req_row = '0;
    logic [7:0] req_col = '0;
    logic req_ap = 1'b0;
    logic cs_n, ras_n, cas_n, we_n;
    logic [1:0] ba;
    logic [10:0] addr;

    always #4 clk = ~clk;

    sdram_cmd_seq uut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_bank(req_bank), .req_row(req_row),
        .req_col(req_col), .req_ap(req_ap),
        .cmd_cs_n(cs_n), .cmd_ras_n(ras_n), .cmd_cas_n(cas_n), .cmd_we_n(we_n),
        .cmd_ba(ba), .cmd_addr(addr)
    );

    typedef struct {
        logic [1:0]  op;
        logic [1:0]  bank;
        logic [10:0] row;
        logic [7:0]  col;
        logic        ap;
        logic        exp_hit;
        logic        exp_pre;
    } item_t;

    item_t sb[$];
    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 0;

    // bench-side model of the banks
    bit   mopen [4];
    logic [10:0] mrow [4];
    int   t_act [4];
    int   t_pre [4];
    int   t_act_any = -1000;
    int   t_ref = -1000;
    int   t_mrs = -1000;
    int   n_act = 0, n_pre = 0, ref_cnt = 0;
    bit   seen_ready = 0;
    int   boot_n = 0;
    logic [3:0] boot_cmd [4];
    logic boot_a10 [4];
    int   first_cmd_cyc = -1;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    initial begin
        for (int b = 0; b < 4; b++) begin
            mopen[b] = 0; mrow[b] = '0; t_act[b] = -1000; t_pre[b] = -1000;
        end
    end

    // ---------------- monitor ----------------
    always @(negedge clk) begin
        if (rst_n) begin
            logic [3:0] c;
            cyc++;
            c = {cs_n, ras_n, cas_n, we_n};
            if (req_ready) begin
                chk(c == 4'b0111, "R3 ready with nop", int'(c), 7);
                if (!seen_ready) begin
                    seen_ready = 1;
                    chk(boot_n == 4, "R2 boot count", boot_n, 4);
                    chk(first_cmd_cyc >= INIT_CYC, "R2 boot wait", first_cmd_cyc, INIT_CYC);
                    chk(boot_cmd[0] == 4'b0010 && boot_a10[0], "R2 boot pall", int'(boot_cmd[0]), 2);
                    chk(boot_cmd[1] == 4'b0001, "R2 boot ref1", int'(boot_cmd[1]), 1);
                    chk(boot_cmd[2] == 4'b0001, "R2 boot ref2", int'(boot_cmd[2]), 1);
                    chk(boot_cmd[3] == 4'b0000, "R2 boot mode", int'(boot_cmd[3]), 0);
                end
            end
            if (c != 4'b0111) begin
                if (!seen_ready) begin
                    if (first_cmd_cyc < 0) first_cmd_cyc = cyc;
                    if (boot_n < 4) begin
                        boot_cmd[boot_n] = c;
                        boot_a10[boot_n] = addr[10];
                    end
                    boot_n++;
                end
                chk(cyc - t_ref >= T_RC, "R8 gap after refresh", cyc - t_ref, T_RC);
                chk(cyc - t_mrs >= T_MRD, "R7 gap after mode", cyc - t_mrs, T_MRD);
                case (c)
                    4'b0011: begin // activate (R4)
                        chk(!mopen[ba], "R4 act to closed bank", int'(mopen[ba]), 0);
                        chk(cyc - t_pre[ba] >= T_RP, "R6 tRP", cyc - t_pre[ba], T_RP);
                        chk(cyc - t_act[ba] >= T_RC, "R6 tRC", cyc - t_act[ba], T_RC);
                        chk(cyc - t_act_any >= T_RRD, "R6 tRRD", cyc - t_act_any, T_RRD);
                        if (sb.size() > 0) begin
                            chk(addr == sb[0].row, "R4 act row", int'(addr), int'(sb[0].row));
                            chk(ba == sb[0].bank, "R4 act bank", int'(ba), int'(sb[0].bank));
                        end
                        mopen[ba] = 1; mrow[ba] = addr;
                        t_act[ba] = cyc; t_act_any = cyc; n_act++;
                    end
                    4'b0010: begin // precharge
                        if (addr[10]) begin
                            for (int b = 0; b < 4; b++) begin
                                if (mopen[b]) begin
                                    chk(cyc - t_act[b] >= T_RAS, "R6 tRAS pall", cyc - t_act[b], T_RAS);
                                    mopen[b] = 0; t_pre[b] = cyc;
                                end
                            end
                        end else begin
                            chk(mopen[ba], "R4 pre to open bank", int'(mopen[ba]), 1);
                            chk(cyc - t_act[ba] >= T_RAS, "R6 tRAS", cyc - t_act[ba], T_RAS);
                            mopen[ba] = 0; t_pre[ba] = cyc; n_pre++;
                        end
                    end
                    4'b0101, 4'b0100: begin // read / write
                        chk(sb.size() > 0, "R4 unexpected column", sb.size(), 1);
                        if (sb.size() > 0) begin
                            item_t it;
                            it = sb.pop_front();
                            chk((c == 4'b0100) == (it.op == 2'd1), "R4 column kind", int'(c), int'(it.op));
                            chk(ba == it.bank, "R4 column bank", int'(ba), int'(it.bank));
                            chk(addr[7:0] == it.col, "R4 column addr", int'(addr[7:0]), int'(it.col));
                            chk(addr[10] == it.ap, "R4 ap bit", int'(addr[10]), int'(it.ap));
                            chk(mopen[ba] && mrow[ba] == it.row, "R4 row open", int'(mrow[ba]), int'(it.row));
                            chk(cyc - t_act[ba] >= T_RCD, "R6 tRCD", cyc - t_act[ba], T_RCD);
                            if (it.exp_hit)
                                chk(n_act == 0 && n_pre == 0, "R4 hit cost", n_act * 10 + n_pre, 0);
                            else if (it.exp_pre)
                                chk(n_act == 1 && n_pre == 1, "R4 conflict cost", n_act * 10 + n_pre, 11);
                            else
                                chk(n_act == 1 && n_pre == 0, "R5 closed miss cost", n_act * 10 + n_pre, 10);
                        end
                        n_act = 0; n_pre = 0;
                        if (addr[10]) begin
                            mopen[ba] = 0; t_pre[ba] = cyc + 4;
                        end
                    end
                    4'b0001: begin // auto refresh
                        for (int b = 0; b < 4; b++) begin
                            chk(!mopen[b], "R8 bank closed at refresh", int'(mopen[b]), 0);
                            chk(cyc - t_pre[b] >= T_RP, "R8 tRP before refresh", cyc - t_pre[b], T_RP);
                        end
                        if (seen_ready)
                            chk(cyc - t_ref <= REF_CYC + 40, "R9 refresh interval", cyc - t_ref, REF_CYC + 40);
                        t_ref = cyc; ref_cnt++;
                    end
                    4'b0000: begin // mode set
                        for (int b = 0; b < 4; b++)
                            chk(!mopen[b], "R7 bank closed at mode", int'(mopen[b]), 0);
                        if (!seen_ready) begin
                            chk(addr == BOOT_MODE, "R2 boot mode word", int'(addr), int'(BOOT_MODE));
                        end else begin
                            chk(sb.size() > 0 && sb[0].op == 2'd3, "R7 mode expected", sb.size(), 1);
                            if (sb.size() > 0) begin
                                item_t it;
                                it = sb.pop_front();
                                chk(addr == it.row, "R7 mode word", int'(addr), int'(it.row));
                            end
                        end
                        t_mrs = cyc;
                    end
                    default: chk(1'b0, "R1 illegal command pattern", int'(c), 7);
                endcase
            end
        end
    end

    // ---------------- driver ----------------
    task automatic send(input logic [1:0] op, input logic [1:0] bank,
                        input logic [10:0] row, input logic [7:0] col, input logic ap);
        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_bank = bank;
        req_row = row; req_col = col; req_ap = ap;
        #1;
        while (!req_ready) begin
            @(negedge clk);
            #1;
        end
        if (op != 2'd2) begin
            item_t it;
            it.op = op; it.bank = bank; it.row = row; it.col = col; it.ap = ap;
            it.exp_hit = mopen[bank] && mrow[bank] == row;
            it.exp_pre = mopen[bank] && mrow[bank] != row;
            sb.push_back(it);
        end
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic settle();
        int n;
        n = 0;
        while ((sb.size() != 0 || !req_ready) && n < 200) begin
            @(negedge clk);
            n++;
        end
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // ---------------- main sequence ----------------
    initial begin
        int rc;
        logic [31:0] lcg;
        repeat (3) @(negedge clk);
        chk(req_ready == 1'b0, "R2 ready low in reset", int'(req_ready), 0);
        chk({cs_n, ras_n, cas_n, we_n} == 4'b0111, "R2 nop in reset",
            int'({cs_n, ras_n, cas_n, we_n}), 7);
        rst_n = 1'b1;

        // closed miss, then hit, then row conflict (R4)
        send(2'd1, 2'd0, 11'd5, 8'h10, 1'b0);
        send(2'd0, 2'd0, 11'd5, 8'h20, 1'b0);
        send(2'd0, 2'd0, 11'd9, 8'h33, 1'b0);
        settle();

        // auto-precharge then reaccess the same row (R5)
        send(2'd1, 2'd1, 11'd3, 8'h44, 1'b1);
        send(2'd0, 2'd1, 11'd3, 8'h45, 1'b0);
        settle();
        chk(mopen[1] == 1'b1, "R5 reopened after ap", int'(mopen[1]), 1);

        // two banks back to back (R6 tRRD)
        send(2'd0, 2'd2, 11'd100, 8'h01, 1'b0);
        send(2'd0, 2'd3, 11'd200, 8'h02, 1'b0);
        settle();

        // mode set with banks open (R7)
        send(2'd3, 2'd0, 11'h022, 8'h00, 1'b0);
        settle();
        chk(mopen[0] == 0 && mopen[2] == 0, "R7 banks closed by mode", int'(mopen[0]), 0);

        // user refresh (R10)
        send(2'd0, 2'd2, 11'd7, 8'h09, 1'b0);
        settle();
        rc = ref_cnt;
        send(2'd2, 2'd0, 11'd0, 8'h00, 1'b0);
        repeat (30) @(negedge clk);
        chk(ref_cnt > rc, "R10 refresh on request", ref_cnt - rc, 1);

        // idle: periodic refresh (R9)
        rc = ref_cnt;
        repeat (4500) @(negedge clk);
        chk(ref_cnt - rc >= 2, "R9 periodic refresh count", ref_cnt - rc, 2);

        // mixed traffic
        lcg = 32'h1234_5678;
        for (int i = 0; i < 40; i++) begin
            lcg = lcg * 32'd1103515245 + 32'd12345;
            send({1'b0, lcg[20]}, lcg[18:17], 11'(lcg[22] + 1), lcg[30:23],
                 lcg[25:24] == 2'b00);
        end
        settle();
        repeat (20) @(negedge clk);
        chk(sb.size() == 0, "R4 all requests served", sb.size(), 0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule